// File: doc/BRIEF.md
# Shared-Pin Master/Slave Role Arbiter

This block chooses whether a redundant clock unit runs as the master of a pair or as a slave that follows its partner. The role command arrives on a pin that also carries the frame-sync of the serial management bus. A level on that pin is taken as a role command only after it has stayed put for a full hold window with no activity on the serial clock. Ordinary bus framing therefore never flips the role.

A companion flag reports whether the signal coming from the partner unit is usable. While that flag is low the unit is always master, whatever is asked. Software can take over through a register-control enable. In that mode the pin is not looked at and a register bit picks the role. The pin and the serial clock are asynchronous and pass through two-stage synchronisers. The flag and the register bits are already in the block's clock domain.

Top module: `role_arbiter`

## Requirements
- R1: After reset the role output `is_slave` is 0 (master).
- R2: In pin control, with the partner flag high, a master becomes a slave when the pin has been low for HOLD_CYCLES clocks with no serial-clock edge. `is_slave` rises exactly HOLD_CYCLES+4 clock edges after the pin change is first sampled, and not earlier.
- R3: In pin control, a slave becomes master when the pin has been high for HOLD_CYCLES clocks with no serial-clock edge, with the same latency as R2.
- R4: Every serial-clock edge, rising or falling, restarts the hold window. The role can change only HOLD_CYCLES+4 edges after the last serial-clock toggle is first sampled.
- R5: A pin level held for less than the hold window has no effect on the role.
- R6: When the partner flag is low, `is_slave` is 0 on the next clock edge and stays 0 while the flag is low, in every mode.
- R7: A slave request made while the partner flag is low takes effect on the first clock edge after the flag goes high, if the qualified pin level is still low.
- R8: With `reg_ctrl_en` = 1 the pin is ignored. `reg_slave` = 1 selects slave and `reg_slave` = 0 selects master, effective on the next clock edge.
- R9: In register control, `reg_slave` = 1 with the partner flag low still yields master. The unit becomes slave on the edge after the flag returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_pin | input | 1 | Shared role / frame-sync pin, asynchronous (1 = master request, 0 = slave request) |
| ser_clk | input | 1 | Serial bus clock, asynchronous, watched for activity only |
| partner_ok | input | 1 | Partner clock input valid flag |
| reg_ctrl_en | input | 1 | 1 = register bit controls the role, pin ignored |
| reg_slave | input | 1 | Register role request (1 = slave, 0 = master) |
| is_slave | output | 1 | Current role (1 = slave, 0 = master) |

## Verification
The role is a single register that drives `is_slave` directly, so a wrong internal state shows at the port on the very edge it is taken. A hold counter that restarts late or saturates early moves the switching edge away from the exact HOLD_CYCLES+4 point. The bench therefore samples the cycle before and the cycle of the expected change. A missed restart on serial-clock activity shows as a role change during a bus burst. A missed partner-flag override shows as `is_slave` still high one edge after the flag drops.

// File: rtl/role_arb_pkg.sv
package role_arb_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/role_sync.sv
// Multi-bit two-stage synchroniser with per-bit reset value.
module role_sync #(
  parameter int          WIDTH     = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/role_hold_timer.sv
// Qualifies a pin level once it has been stable, with no serial-clock
// edge, for HOLD_CYCLES clocks.
module role_hold_timer #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic sclk_s,
  output logic hold_met,
  output logic pin_lvl
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic          sclk_d;
  logic          pin_d;
  logic [CW-1:0] cnt;
  logic          restart;

  assign restart = (sclk_s != sclk_d) || (pin_s != pin_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      pin_d  <= 1'b1;
      cnt    <= '0;
    end else begin
      sclk_d <= sclk_s;
      pin_d  <= pin_s;
      if (restart)
        cnt <= '0;
      else if (cnt != LIMIT)
        cnt <= cnt + 1'b1;
    end
  end

  assign hold_met = (cnt == LIMIT);
  assign pin_lvl  = pin_d;
endmodule

// File: rtl/role_fsm.sv
module role_fsm
  import role_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_met,
  input  logic pin_lvl,
  input  logic partner_ok,
  input  logic reg_ctrl_en,
  input  logic reg_slave,
  output logic is_slave
);
  role_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (!partner_ok) begin
      state_nx = ROLE_MASTER;
    end else if (reg_ctrl_en) begin
      state_nx = reg_slave ? ROLE_SLAVE : ROLE_MASTER;
    end else if (hold_met) begin
      state_nx = pin_lvl ? ROLE_MASTER : ROLE_SLAVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ROLE_MASTER;
    else        state <= state_nx;
  end

  assign is_slave = (state == ROLE_SLAVE);
endmodule

// File: rtl/role_arbiter.sv
module role_arbiter #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic role_pin,
  input  logic ser_clk,
  input  logic partner_ok,
  input  logic reg_ctrl_en,
  input  logic reg_slave,
  output logic is_slave
);
  logic [1:0] sync_q;
  logic       hold_met;
  logic       pin_lvl;

  // bit 1: role pin (idles high = master), bit 0: serial clock
  role_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({role_pin, ser_clk}),
    .q_sync  (sync_q)
  );

  role_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (sync_q[1]),
    .sclk_s   (sync_q[0]),
    .hold_met (hold_met),
    .pin_lvl  (pin_lvl)
  );

  role_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_met    (hold_met),
    .pin_lvl     (pin_lvl),
    .partner_ok  (partner_ok),
    .reg_ctrl_en (reg_ctrl_en),
    .reg_slave   (reg_slave),
    .is_slave    (is_slave)
  );
endmodule

// File: rtl/role_arbiter_chk.sv
module role_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic partner_ok,
  input logic reg_ctrl_en,
  input logic reg_slave,
  input logic hold_met,
  input logic pin_lvl,
  input logic is_slave
);
  AST_PARTNER_LOSS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !partner_ok |=> !is_slave); // R6

  AST_REG_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ctrl_en && partner_ok) |=> (is_slave == $past(reg_slave))); // R8

  AST_UNQUALIFIED_PIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_ctrl_en && partner_ok && !hold_met) |=> $stable(is_slave)); // R5

  AST_HIGH_LEVEL_KEEPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_ctrl_en && !is_slave && hold_met && pin_lvl) |=> !is_slave); // R3

  AST_LOW_LEVEL_TO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_ctrl_en && partner_ok && hold_met && !pin_lvl) |=> is_slave); // R2
endmodule

bind role_arbiter role_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .partner_ok  (partner_ok),
  .reg_ctrl_en (reg_ctrl_en),
  .reg_slave   (reg_slave),
  .hold_met    (hold_met),
  .pin_lvl     (pin_lvl),
  .is_slave    (is_slave)
);

// File: tb/role_arbiter_tb.sv
`timescale 1ns/1ps
module role_arbiter_tb;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_pin = 1'b1;
  logic ser_clk = 1'b0;
  logic partner_ok = 1'b1;
  logic reg_ctrl_en = 1'b0;
  logic reg_slave = 1'b0;
  logic is_slave;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  role_arbiter #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_pin    (role_pin),
    .ser_clk     (ser_clk),
    .partner_ok  (partner_ok),
    .reg_ctrl_en (reg_ctrl_en),
    .reg_slave   (reg_slave),
    .is_slave    (is_slave)
  );

  // driver side: queue an expectation 'dt' cycles from now
  task automatic expect_at(input int dt, input bit v, input string tag);
    exp_t e;
    e.at = cyc + dt; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare at the scheduled cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      n_tests++;
      if (sb[0].at < cyc) begin
        n_fail++;
        $display("FAIL %s: sample missed at cycle %0d (actual %0b expected %0b)",
                 sb[0].tag, sb[0].at, is_slave, sb[0].val);
      end else if (is_slave !== sb[0].val) begin
        n_fail++;
        $display("FAIL %s: cycle %0d is_slave actual %0b expected %0b",
                 sb[0].tag, cyc, is_slave, sb[0].val);
      end
      void'(sb.pop_front());
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_at(1, 1'b0, "R1"); drain();

    // R5: short low pulse
    role_pin = 1'b0; idle(HOLD / 2); role_pin = 1'b1;
    expect_at(HOLD + 10, 1'b0, "R5"); drain();

    // R2: long low -> slave, exact edge
    role_pin = 1'b0;
    expect_at(HOLD + 3, 1'b0, "R2");
    expect_at(HOLD + 4, 1'b1, "R2");
    drain();

    // R3: long high -> master
    role_pin = 1'b1;
    expect_at(HOLD + 3, 1'b1, "R3");
    expect_at(HOLD + 4, 1'b0, "R3");
    drain();

    // R4: bus activity keeps restarting the window
    role_pin = 1'b0;
    for (int i = 0; i < 20; i++) begin
      idle(10);
      ser_clk = ~ser_clk;
      if (i == 10) expect_at(1, 1'b0, "R4");
    end
    expect_at(HOLD + 3, 1'b0, "R4");
    expect_at(HOLD + 4, 1'b1, "R4");
    drain();

    // R6: partner loss forces master next edge
    partner_ok = 1'b0;
    expect_at(1, 1'b0, "R6");
    expect_at(2 * HOLD, 1'b0, "R6");
    drain();

    // R7: pending slave request applies once partner returns
    partner_ok = 1'b1;
    expect_at(1, 1'b1, "R7"); drain();

    // back to master via pin, then register control
    role_pin = 1'b1; idle(HOLD + 6);
    expect_at(0, 1'b0, "R3"); drain();

    reg_ctrl_en = 1'b1; reg_slave = 1'b1;
    expect_at(1, 1'b1, "R8");
    expect_at(2 * HOLD, 1'b1, "R8");
    drain();
    reg_slave = 1'b0;
    expect_at(1, 1'b0, "R8"); drain();
    role_pin = 1'b0;
    expect_at(HOLD + 10, 1'b0, "R8"); drain();

    // R9: register slave with partner invalid
    reg_slave = 1'b1; partner_ok = 1'b0;
    expect_at(1, 1'b0, "R9");
    expect_at(5, 1'b0, "R9");
    drain();
    partner_ok = 1'b1;
    expect_at(1, 1'b1, "R9"); drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule